// File: doc/BRIEF.md
# Pin-Strap Configuration Scanner

This block decides, once per power-up, how a set of four strap inputs has been wired on the board. Each strap (current-gain select, pulse-rate select, coarse calibration, fine calibration) is jumpered to exactly one of seven program-select lines. The line numbered 1 is the digital ground pin and always reads low. The line numbered 7 is the digital supply pin and always reads high. The block owns lines 2 to 6 and drives them with a three-phase binary pattern: in phase k, line j carries bit k of the number j. It waits a parameterised settle time in each phase and then samples every strap. The three samples of one strap, read as a binary number, give the line it is tied to. An all-low reading means line 1 and an all-high reading means line 7.

The four line numbers are then turned into operating settings: current-channel gain, the two high-pass filter enables, pulse output format and rate, and a signed calibration trim counted in 0.2 % steps. When the scan ends, the block stops driving and sampling, raises `ready`, and freezes its results. Two digital flags from an external supply monitor control the rescan. The low-threshold flag forces the block back to its idle state. A new scan starts only once the high-threshold flag is seen. The shared pads can then return to their normal jobs when `scan_active` is low.

Top module: `strap_cfg_scanner`

## Requirements
- R1: After reset, and one cycle after `sup_below_lo` is seen high, `ready`=0, `scan_active`=0, `psel_drv`=0, `strap_err`=0, and the settings hold the line-4 values: `gain_x50`=1, `hpf_cur_en`=1, `hpf_volt_en`=1, `pulse_counter_mode`=0, `pulse_rate_code`=3, `cal_steps`=0.
- R2: A scan has three phases, each lasting exactly SETTLE_CYC cycles. In phase k, bit j-2 of `psel_drv` (line j, j=2..6) carries bit k of j. This gives 5'b01010, then 5'b10011, then 5'b11100. Outside a scan, `psel_drv` is 0.
- R3: A scan starts on the edge after `sup_above_hi`=1 while `sup_below_lo`=0. After the low flag drops, the block stays idle for as long as the high flag is 0.
- R4: `sup_below_lo`=1 ends a scan in progress, or a finished result, on the next edge. A later start runs the full scan again.
- R5: A strap's samples form a code {phase2, phase1, phase0}. Code 0 identifies line 1, code 7 identifies line 7, and codes 2 to 6 identify the line of that number.
- R6: The gain strap on line n gives `gain_x50`=1 for n in {2,4,6}. It gives `hpf_cur_en`=1 for n in 3..6 and `hpf_volt_en`=1 for n in {3,4,7}.
- R7: The rate strap on line n gives `pulse_counter_mode`=1 for n≥6. `pulse_rate_code` equals log2(4·Hz): n-1 for n=1..5 (0.25 to 4 Hz stepper), 3 for n=6 (2 Hz counter), and 6 for n=7 (16 Hz counter).
- R8: `cal_steps` = 7·(4-c) + (4-f), with c and f the coarse and fine strap lines. The value is signed and lies within -24..+24.
- R9: Code 1 matches no line. It sets that strap's bit of `strap_err` (bit 0 gain, 1 rate, 2 coarse, 3 fine) and decodes that strap as line 4.
- R10: While `ready`=1, changes on `strap_in` have no effect on any output.
- R11: `ready` rises, and the settings take their new values, on the edge that ends the last settle cycle: 3·SETTLE_CYC+1 edges after the start condition is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sup_below_lo | input | 1 | Supply monitor: below low threshold |
| sup_above_hi | input | 1 | Supply monitor: above high threshold |
| strap_in | input | 4 | Strap readings: gain, rate, coarse cal, fine cal |
| psel_drv | output | 5 | Drive values for program-select lines 2..6 |
| scan_active | output | 1 | Block owns the select lines and samples straps |
| ready | output | 1 | Scan finished, settings valid |
| gain_x50 | output | 1 | Current channel at 50x (100 mVpp) instead of 10x |
| hpf_cur_en | output | 1 | Current-channel high-pass filter on |
| hpf_volt_en | output | 1 | Voltage-channel high-pass filter on |
| pulse_counter_mode | output | 1 | Counter pulse format instead of stepper |
| pulse_rate_code | output | 3 | Full-scale pulse rate, log2(4·Hz) |
| cal_steps | output | 6 | Signed calibration trim in 0.2 % steps |
| strap_err | output | 4 | Per-strap inconsistent-reading flag |

## Verification
On every cycle, the embedded properties check four things: the select lines carry only the three legal patterns and are quiet outside a scan; a scan never starts without the high supply flag; the low flag clears `ready`; and a held result does not move. They also check that a flagged strap sits at the line-4 fallback and that the calibration trim stays within range. Only the bench's scenarios can show that each wiring decodes to the right setting. The bench sweeps all 2401 combinations of the four straps, times a scan to the exact cycle, aborts scans partway through, tests the two-flag hysteresis, and miswires straps one at a time to produce error codes.

// File: rtl/strap_scan_pkg.sv
package strap_scan_pkg;
  localparam int NUM_STRAPS = 4;
  localparam int FIRST_LINE = 2;
  localparam int NUM_LINES  = 5;
  localparam int PHASES     = 3;
  localparam int IDX_W      = PHASES;
  localparam logic [IDX_W-1:0] FALLBACK_LINE = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_e;

  function automatic logic line_bit(input int line, input logic [1:0] phase);
    return 1'((line >> phase) & 1);
  endfunction
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/strap_scan_fsm.sv
module strap_scan_fsm
  import strap_scan_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sup_below_lo,
  input  logic                              sup_above_hi,
  input  logic [NUM_STRAPS-1:0]             strap_in,
  output logic [NUM_LINES-1:0]              psel_drv,
  output logic                              scan_active,
  output logic                              ready,
  output logic                              load,
  output logic [NUM_STRAPS-1:0][IDX_W-1:0]  raw_code
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [1:0] PH_LAST = 2'(PHASES - 1);

  scan_state_e state_q, state_d;
  logic [1:0]  phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NUM_STRAPS-1:0][PHASES-2:0] samp_q, samp_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    samp_d  = samp_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sup_above_hi && !sup_below_lo) begin
          state_d = ST_SCAN;
          phase_d = 2'd0;
          cnt_d   = '0;
        end
      end
      ST_SCAN: begin
        if (sup_below_lo) begin
          state_d = ST_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          for (int s = 0; s < NUM_STRAPS; s++) begin
            if (phase_q == 2'd0) samp_d[s][0] = strap_in[s];
            else if (phase_q == 2'd1) samp_d[s][1] = strap_in[s];
          end
          if (phase_q == PH_LAST) begin
            state_d = ST_DONE;
            load    = 1'b1;
          end else begin
            phase_d = phase_q + 2'd1;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_DONE: begin
        if (sup_below_lo) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 2'd0;
      cnt_q   <= '0;
      samp_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      samp_q  <= samp_d;
    end
  end

  assign scan_active = (state_q == ST_SCAN);
  assign ready       = (state_q == ST_DONE);

  for (genvar s = 0; s < NUM_STRAPS; s++) begin : g_code
    assign raw_code[s] = {strap_in[s], samp_q[s]};
  end

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
    assign psel_drv[j] = scan_active & line_bit(j + FIRST_LINE, phase_q);
  end

  // R2: lines are quiet outside a scan
  p_idle_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_active |-> psel_drv == '0);
  // R2: only the three phase patterns appear on the lines
  p_pattern_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active |-> (psel_drv == 5'b01010 || psel_drv == 5'b10011 || psel_drv == 5'b11100));
  // R3: a scan begins only after the high flag with the low flag clear
  p_start_needs_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_active) |-> $past(sup_above_hi && !sup_below_lo));
endmodule

// File: rtl/strap_resolve.sv
module strap_resolve
  import strap_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [IDX_W-1:0] code,
  output logic [IDX_W-1:0] line_q,
  output logic             err_q
);
  logic [IDX_W-1:0] line_d;
  logic             err_d;

  always_comb begin
    line_d = line_q;
    err_d  = err_q;
    if (clr) begin
      line_d = FALLBACK_LINE;
      err_d  = 1'b0;
    end else if (load) begin
      unique case (code)
        3'd0:    begin line_d = 3'd1;          err_d = 1'b0; end
        3'd1:    begin line_d = FALLBACK_LINE; err_d = 1'b1; end
        default: begin line_d = code;          err_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= FALLBACK_LINE;
      err_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      err_q  <= err_d;
    end
  end

  // R9: a flagged strap always holds the fallback line
  p_err_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> line_q == FALLBACK_LINE);
  // R5: a resolved line number is never zero
  p_line_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_q != 3'd0);
endmodule

// File: rtl/strap_cfg_scanner.sv
module strap_cfg_scanner
  import strap_scan_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sup_below_lo,
  input  logic        sup_above_hi,
  input  logic [3:0]  strap_in,
  output logic [4:0]  psel_drv,
  output logic        scan_active,
  output logic        ready,
  output logic        gain_x50,
  output logic        hpf_cur_en,
  output logic        hpf_volt_en,
  output logic        pulse_counter_mode,
  output logic [2:0]  pulse_rate_code,
  output logic [5:0]  cal_steps,
  output logic [3:0]  strap_err
);
  localparam int S_GAIN = 0;
  localparam int S_RATE = 1;
  localparam int S_CRS  = 2;
  localparam int S_FINE = 3;

  logic rst_sync_n;
  logic load;
  logic [NUM_STRAPS-1:0][IDX_W-1:0] raw_code;
  logic [NUM_STRAPS-1:0][IDX_W-1:0] line;

  strap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  strap_scan_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .sup_below_lo (sup_below_lo),
    .sup_above_hi (sup_above_hi),
    .strap_in     (strap_in),
    .psel_drv     (psel_drv),
    .scan_active  (scan_active),
    .ready        (ready),
    .load         (load),
    .raw_code     (raw_code)
  );

  for (genvar s = 0; s < NUM_STRAPS; s++) begin : g_strap
    strap_resolve u_res (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clr    (sup_below_lo),
      .load   (load),
      .code   (raw_code[s]),
      .line_q (line[s]),
      .err_q  (strap_err[s])
    );
  end

  logic [IDX_W-1:0] g_ln, r_ln;
  assign g_ln = line[S_GAIN];
  assign r_ln = line[S_RATE];

  always_comb begin
    gain_x50    = (g_ln == 3'd2) || (g_ln == 3'd4) || (g_ln == 3'd6);
    hpf_cur_en  = (g_ln >= 3'd3) && (g_ln <= 3'd6);
    hpf_volt_en = (g_ln == 3'd3) || (g_ln == 3'd4) || (g_ln == 3'd7);
    pulse_counter_mode = (r_ln >= 3'd6);
    if (r_ln <= 3'd5)      pulse_rate_code = r_ln - 3'd1;
    else if (r_ln == 3'd6) pulse_rate_code = 3'd3;
    else                   pulse_rate_code = 3'd6;
    cal_steps = 6'(7 * (4 - int'(line[S_CRS])) + (4 - int'(line[S_FINE])));
  end

  // R4: the low supply flag withdraws ready on the next edge
  p_lo_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sup_below_lo |=> !ready);
  // R10: a held result does not change
  p_ready_stable_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ready && $past(ready)) |-> ($stable(line) && $stable(strap_err)));
  // R8: calibration trim stays in range
  p_cal_range_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($signed(cal_steps) <= 6'sd24) && ($signed(cal_steps) >= -6'sd24));
endmodule

// File: tb/strap_cfg_scanner_bench.sv
module strap_cfg_scanner_bench;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_lo = 1'b1;
  logic sup_hi = 1'b0;
  logic [3:0] strap_in;
  logic [4:0] psel_drv;
  logic scan_active, ready, gain_x50, hpf_cur_en, hpf_volt_en, pulse_counter_mode;
  logic [2:0] pulse_rate_code;
  logic [5:0] cal_steps;
  logic [3:0] strap_err;
  logic [3:0] sel [4];   // 1..7 = line number, 8 = miswired (reads code 1)

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  strap_cfg_scanner #(.SETTLE_CYC(SETTLE)) u_strap_cfg_scanner (
    .clk(clk), .rst_n(rst_n), .sup_below_lo(sup_lo), .sup_above_hi(sup_hi),
    .strap_in(strap_in), .psel_drv(psel_drv), .scan_active(scan_active),
    .ready(ready), .gain_x50(gain_x50), .hpf_cur_en(hpf_cur_en),
    .hpf_volt_en(hpf_volt_en), .pulse_counter_mode(pulse_counter_mode),
    .pulse_rate_code(pulse_rate_code), .cal_steps(cal_steps), .strap_err(strap_err)
  );

  // Board model: each strap follows the line it is jumpered to
  always_comb begin
    for (int s = 0; s < 4; s++) begin
      case (sel[s])
        4'd1:    strap_in[s] = 1'b0;
        4'd7:    strap_in[s] = 1'b1;
        4'd8:    strap_in[s] = psel_drv[1] & psel_drv[3];
        default: strap_in[s] = (sel[s] >= 4'd2 && sel[s] <= 4'd6) ? psel_drv[sel[s] - 4'd2] : 1'b0;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_settings(input int g, input int r, input int c, input int f, input int err);
    int ge = (err & 1) ? 4 : g;
    int re = (err & 2) ? 4 : r;
    int ce = (err & 4) ? 4 : c;
    int fe = (err & 8) ? 4 : f;
    chk("R6 gain_x50", gain_x50, (ge % 2 == 0) ? 1 : 0);
    chk("R6 hpf_cur_en", hpf_cur_en, (ge >= 3 && ge <= 6) ? 1 : 0);
    chk("R6 hpf_volt_en", hpf_volt_en, (ge == 3 || ge == 4 || ge == 7) ? 1 : 0);
    chk("R7 counter_mode", pulse_counter_mode, (re >= 6) ? 1 : 0);
    chk("R7 rate_code", pulse_rate_code, (re <= 5) ? re - 1 : (re == 6 ? 3 : 6));
    chk("R8 cal_steps", int'($signed(cal_steps)), 7 * (4 - ce) + (4 - fe));
    chk("R9 strap_err", strap_err, err);
  endtask

  task automatic chk_idle();
    chk("R1 ready", ready, 0);
    chk("R1 scan_active", scan_active, 0);
    chk("R1 psel_drv", psel_drv, 0);
    chk_settings(4, 4, 4, 4, 0);
  endtask

  task automatic set_straps(input int g, input int r, input int c, input int f);
    sel[0] = 4'(g); sel[1] = 4'(r); sel[2] = 4'(c); sel[3] = 4'(f);
  endtask

  // power dip then full scan; leaves the bench at a negedge with ready sampled
  task automatic power_scan();
    int t;
    @(negedge clk); sup_lo = 1'b1; sup_hi = 1'b0;
    @(negedge clk); sup_lo = 1'b0; sup_hi = 1'b1;
    t = 0;
    do begin @(negedge clk); t++; end while (!ready && t < 100);
    chk("R11 scan_len", t, 3 * SETTLE + 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int expd [3];
    set_straps(4, 4, 4, 4);
    repeat (3) @(negedge clk);
    chk_idle();                      // R1 under reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle();                      // R1 after release, supply low

    // R3: low flag gone, high flag absent -> stay idle
    sup_lo = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3 no_start", scan_active, 0);
    chk("R3 no_ready", ready, 0);

    // R2/R11: timed scan with pattern capture
    set_straps(2, 5, 3, 6);
    expd[0] = 5'b01010; expd[1] = 5'b10011; expd[2] = 5'b11100;
    sup_hi = 1'b1;
    for (int k = 1; k <= 3 * SETTLE; k++) begin
      @(negedge clk);
      chk("R2 scan_active", scan_active, 1);
      chk("R2 pattern", psel_drv, expd[(k - 1) / SETTLE]);
      chk("R11 not_ready", ready, 0);
    end
    @(negedge clk);
    chk("R11 ready", ready, 1);
    chk("R2 lines_released", psel_drv, 0);
    chk_settings(2, 5, 3, 6, 0);

    // R10: straps changed after completion are ignored
    set_straps(7, 1, 1, 7);
    repeat (30) @(negedge clk);
    chk("R10 ready_held", ready, 1);
    chk_settings(2, 5, 3, 6, 0);

    // R4/R1: low flag on a finished result
    sup_lo = 1'b1;
    @(negedge clk);
    chk_idle();
    sup_lo = 1'b0;

    // R4: abort mid-scan, then rescan completes with new wiring
    set_straps(6, 7, 1, 2);
    @(negedge clk);
    repeat (SETTLE + 2) @(negedge clk);
    chk("R4 mid_scan", scan_active, 1);
    sup_lo = 1'b1;
    @(negedge clk);
    chk("R4 aborted", scan_active, 0);
    chk("R4 no_ready", ready, 0);
    power_scan();
    chk_settings(6, 7, 1, 2, 0);

    // R9: miswired strap on each position in turn
    for (int s = 0; s < 4; s++) begin
      set_straps(3, 2, 5, 6);
      sel[s] = 4'd8;
      power_scan();
      chk_settings(3, 2, 5, 6, 1 << s);
    end

    // R5-R8: exhaustive sweep of all wirings, each after a supply dip
    for (int g = 1; g <= 7; g++)
      for (int r = 1; r <= 7; r++)
        for (int c = 1; c <= 7; c++)
          for (int f = 1; f <= 7; f++) begin
            set_straps(g, r, c, f);
            power_scan();
            chk_settings(g, r, c, f, 0);   // R5 line identification via decode
          end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule